// File: doc/BRIEF.md
# RC4 Key-Scrambling Stream Cipher

This block hides a short secret, such as a 128-bit block-cipher key, by XORing it byte by byte with an RC4 keystream. The host first presents a secret key of programmable length and pulses `start`. The core then sets its 256-entry byte permutation to the identity. Next it runs the 256-step key schedule, which swaps entries of the permutation under the control of the repeated key. Only then does it accept data.

In the generation phase the core takes `NUM_BYTES` data bytes on a valid/ready input stream. Each byte advances the generator by one step and is XORed with the keystream byte that step produces. The result leaves on a valid/ready output stream.

An input byte is accepted only when the single-entry output register is empty or is being drained in the same cycle. A stalled consumer therefore stalls the producer without any loss. Decryption is the same operation with the same key. `done` reports that every result byte of the job has left the core.

Top module: `rc4_key_cipher`

## Requirements
- R1: While reset is asserted and right after it is released, `din_ready`, `dout_valid` and `done` are low.
- R2: Key byte n is `key_in[8n+7:8n]`. `key_len` gives the key length in bytes, with 0 treated as 1 and any value above `KEY_MAX` treated as `KEY_MAX`. The permutation starts as S[x]=x. For i = 0 to 255 the schedule sets j = j + S[i] + key[i mod len] (mod 256) and then swaps S[i] and S[j].
- R3: `start` is accepted only while the core is idle. A `start` pulse during a job changes neither the key in use nor the results.
- R4: After the clock edge that accepts `start`, `din_ready` stays low for exactly 257 cycles: one cycle to initialise and one cycle per schedule step.
- R5: Each accepted input byte leaves XORed with the next keystream byte. To produce it, i = i+1, j = j+S[i], S[i] and S[j] are swapped, and the keystream byte is S[(S[i]+S[j]) mod 256]. With key "Key" and data "Plaintext" the output is BB F3 16 E8 D9 40 AF 0A D3.
- R6: Each job accepts exactly `NUM_BYTES` input bytes. After that, `din_ready` stays low until the next job.
- R7: While `dout_valid` is high and `dout_ready` is low, `dout_valid` stays high and `dout_data` holds its value. `din_ready` is low while the output register is full and not being drained.
- R8: `done` rises in the cycle after the last result byte is taken. It stays high until the next `start` is accepted, which clears it.
- R9: Feeding the results back through a second job with the same key returns the original data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; sampled only while idle |
| key_in | input | KEY_MAX*8 | Secret key, byte n in bits 8n+7:8n |
| key_len | input | $clog2(KEY_MAX+1) | Key length in bytes |
| done | output | 1 | All results of the last job delivered |
| din_valid | input | 1 | Input byte present |
| din_ready | output | 1 | Core accepts the input byte |
| din_data | input | 8 | Data byte to encrypt or decrypt |
| dout_valid | output | 1 | Result byte present |
| dout_ready | input | 1 | Consumer takes the result byte |
| dout_data | output | 8 | Result byte |

## Verification
The bench uses the three-byte test key, whose length forces the key index to wrap many times during scheduling; a key-repeat error shows up at once in the published ciphertext. The full 32-byte key, a 5-byte key, and the clamped lengths 0 and 40 catch an off-by-one in the wrap point or in the clamp, either of which gives a different keystream from the first byte on. Irregular output stalls expose a core that overwrites its output register or accepts a byte it cannot store: results would be lost or duplicated. A `start` injected in the middle of a job catches a core that reloads its key while busy, and counting the cycles before the first `din_ready` catches a schedule that runs one step short or long.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
  localparam int PERM_N = 256;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SCHED,
    ST_GEN,
    ST_DRAIN
  } rc4_state_e;
endpackage

// File: rtl/rc4_perm.sv
module rc4_perm
  import rc4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init_en,
  input  logic  swap_en,
  input  byte_t swap_a,
  input  byte_t swap_b,
  input  byte_t rd_a_addr,
  input  byte_t rd_b_addr,
  input  byte_t rd_c_addr,
  output byte_t rd_a_data,
  output byte_t rd_b_data,
  output byte_t rd_c_data
);

  byte_t mem [PERM_N];

  // Identity fill in one cycle, otherwise a two-entry exchange.
  always_ff @(posedge clk) begin
    if (init_en) begin
      for (int k = 0; k < PERM_N; k++) mem[k] <= byte_t'(k);
    end else if (swap_en) begin
      mem[swap_a] <= mem[swap_b];
      mem[swap_b] <= mem[swap_a];
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
  assign rd_c_data = mem[rd_c_addr];

  // R2
  init_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_en |=> (mem[0] == 8'h00 && mem[PERM_N-1] == 8'hFF));

endmodule

// File: rtl/rc4_out_stage.sv
module rc4_out_stage
  import rc4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_data,
  input  logic  dout_ready,
  output logic  dout_valid,
  output byte_t dout_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout_data  <= '0;
    end else if (load) begin
      dout_valid <= 1'b1;
      dout_data  <= load_data;
    end else if (dout_ready) begin
      dout_valid <= 1'b0;
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

endmodule

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
  import rc4_pkg::*;
#(
  parameter int KEY_MAX   = 32,
  parameter int NUM_BYTES = 16,
  localparam int KEY_W    = KEY_MAX * BYTE_W,
  localparam int LEN_W    = $clog2(KEY_MAX + 1),
  localparam int KIDX_W   = $clog2(KEY_MAX),
  localparam int CNT_W    = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key_in,
  input  logic [LEN_W-1:0] key_len,
  input  logic             din_valid,
  input  byte_t            din_data,
  output logic             din_ready,
  input  logic             dout_valid,
  input  logic             dout_ready,
  output logic             init_en,
  output logic             swap_en,
  output byte_t            swap_a,
  output byte_t            swap_b,
  output byte_t            rd_a_addr,
  output byte_t            rd_b_addr,
  output byte_t            rd_c_addr,
  input  byte_t            rd_a_data,
  input  byte_t            rd_b_data,
  input  byte_t            rd_c_data,
  output logic             load,
  output byte_t            load_data,
  output logic             done
);

  rc4_state_e        state;
  logic [KEY_W-1:0]  key_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  len_last;
  logic [KIDX_W-1:0] kidx;
  logic [CNT_W-1:0]  cnt;
  byte_t             i_q, j_q, i_nx, j_new, t_sum, key_byte, ks;
  logic              gen, sched, fire;

  // Clamp the requested key length into 1..KEY_MAX.
  always_comb begin
    if (key_len == '0)                    len_eff = LEN_W'(1);
    else if (key_len > LEN_W'(KEY_MAX))   len_eff = LEN_W'(KEY_MAX);
    else                                  len_eff = key_len;
  end

  assign len_last = len_q - 1'b1;

  // One swap per cycle: both permutation reads, the index update and the
  // keystream pick all settle combinationally before the edge.
  always_comb begin
    gen       = (state == ST_GEN);
    sched     = (state == ST_SCHED);
    i_nx      = i_q + 8'd1;
    key_byte  = key_q[{kidx, 3'b000} +: BYTE_W];
    rd_a_addr = gen ? i_nx : i_q;
    j_new     = j_q + rd_a_data + (sched ? key_byte : 8'h00);
    rd_b_addr = j_new;
    t_sum     = rd_a_data + rd_b_data;
    rd_c_addr = t_sum;
    // The lookup sees pre-swap contents, so redirect hits on the swapped pair.
    if (t_sum == i_nx)       ks = rd_b_data;
    else if (t_sum == j_new) ks = rd_a_data;
    else                     ks = rd_c_data;
    din_ready = gen && (!dout_valid || dout_ready);
    fire      = din_valid && din_ready;
    init_en   = (state == ST_INIT);
    swap_en   = sched || fire;
    swap_a    = rd_a_addr;
    swap_b    = j_new;
    load      = fire;
    load_data = din_data ^ ks;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      key_q <= '0;
      len_q <= LEN_W'(1);
      kidx  <= '0;
      cnt   <= '0;
      i_q   <= '0;
      j_q   <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            key_q <= key_in;
            len_q <= len_eff;
            done  <= 1'b0;
            state <= ST_INIT;
          end
        end
        ST_INIT: begin
          i_q   <= '0;
          j_q   <= '0;
          kidx  <= '0;
          state <= ST_SCHED;
        end
        ST_SCHED: begin
          j_q  <= j_new;
          i_q  <= i_nx;
          kidx <= (LEN_W'(kidx) == len_last) ? '0 : kidx + 1'b1;
          if (i_q == 8'hFF) begin
            i_q   <= '0;
            j_q   <= '0;
            cnt   <= '0;
            state <= ST_GEN;
          end
        end
        ST_GEN: begin
          if (fire) begin
            i_q <= i_nx;
            j_q <= j_new;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(NUM_BYTES - 1)) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (dout_valid && dout_ready) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> ($stable(key_q) && $stable(len_q)));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen |-> (int'(cnt) < NUM_BYTES));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(dout_valid && dout_ready));

endmodule

// File: rtl/rc4_key_cipher.sv
module rc4_key_cipher
  import rc4_pkg::*;
#(
  parameter int KEY_MAX   = 32,
  parameter int NUM_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [KEY_MAX*8-1:0]         key_in,
  input  logic [$clog2(KEY_MAX+1)-1:0] key_len,
  output logic                         done,
  input  logic                         din_valid,
  output logic                         din_ready,
  input  logic [7:0]                   din_data,
  output logic                         dout_valid,
  input  logic                         dout_ready,
  output logic [7:0]                   dout_data
);

  logic  init_en, swap_en, load;
  byte_t swap_a, swap_b, load_data;
  byte_t ra_addr, rb_addr, rc_addr, ra_data, rb_data, rc_data;

  rc4_ctrl #(
    .KEY_MAX  (KEY_MAX),
    .NUM_BYTES(NUM_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .key_in    (key_in),
    .key_len   (key_len),
    .din_valid (din_valid),
    .din_data  (din_data),
    .din_ready (din_ready),
    .dout_valid(dout_valid),
    .dout_ready(dout_ready),
    .init_en   (init_en),
    .swap_en   (swap_en),
    .swap_a    (swap_a),
    .swap_b    (swap_b),
    .rd_a_addr (ra_addr),
    .rd_b_addr (rb_addr),
    .rd_c_addr (rc_addr),
    .rd_a_data (ra_data),
    .rd_b_data (rb_data),
    .rd_c_data (rc_data),
    .load      (load),
    .load_data (load_data),
    .done      (done)
  );

  rc4_perm u_perm (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_en  (init_en),
    .swap_en  (swap_en),
    .swap_a   (swap_a),
    .swap_b   (swap_b),
    .rd_a_addr(ra_addr),
    .rd_b_addr(rb_addr),
    .rd_c_addr(rc_addr),
    .rd_a_data(ra_data),
    .rd_b_data(rb_data),
    .rd_c_data(rc_data)
  );

  rc4_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .dout_ready(dout_ready),
    .dout_valid(dout_valid),
    .dout_data (dout_data)
  );

endmodule

// File: tb/sim_rc4_key_cipher.sv
`timescale 1ns/1ps
module sim_rc4_key_cipher;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [255:0] key_in;
  logic [5:0]   key_len;
  logic         done;
  logic         din_valid;
  logic         din_ready;
  logic [7:0]   din_data;
  logic         dout_valid;
  logic         dout_ready;
  logic [7:0]   dout_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] cur_key [32];
  logic [7:0] cur_dat [16];
  logic [7:0] exp_out [16];
  logic [7:0] got_out [16];
  logic [7:0] orig    [16];

  always #2 clk = ~clk;

  rc4_key_cipher u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .key_in    (key_in),
    .key_len   (key_len),
    .done      (done),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .din_data  (din_data),
    .dout_valid(dout_valid),
    .dout_ready(dout_ready),
    .dout_data (dout_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural keystream model (R2, R5)
  task automatic model(input int len);
    int s [256];
    int i, j, t, tmp, eff;
    eff = (len == 0) ? 1 : (len > 32) ? 32 : len;
    for (int x = 0; x < 256; x++) s[x] = x;
    j = 0;
    for (int x = 0; x < 256; x++) begin
      j = (j + s[x] + int'(cur_key[x % eff])) % 256;
      tmp = s[x]; s[x] = s[j]; s[j] = tmp;
    end
    i = 0; j = 0;
    for (int n = 0; n < 16; n++) begin
      i = (i + 1) % 256;
      j = (j + s[i]) % 256;
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      t = (s[i] + s[j]) % 256;
      exp_out[n] = cur_dat[n] ^ 8'(s[t]);
    end
  endtask

  task automatic run_job(input int len, input int mode, input bit busy_start);
    int in_idx, out_idx, lat, cyc;
    bit pend_in, pend_out, seen, prev_hold, injected;
    logic [7:0] pend_data, prev_data;
    model(len);
    @(negedge clk);
    for (int n = 0; n < 32; n++) key_in[n*8 +: 8] = cur_key[n];
    key_len = 6'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_idx = 0; out_idx = 0; lat = 0; cyc = 0;
    pend_in = 0; pend_out = 0; seen = 0; prev_hold = 0; injected = 0;
    pend_data = '0; prev_data = '0;
    while (out_idx < 16 && cyc < 3000) begin
      if (pend_in) in_idx++;
      if (pend_out) begin
        got_out[out_idx] = pend_data;
        chk(pend_data == exp_out[out_idx], "R5", "result byte", pend_data, exp_out[out_idx]);
        out_idx++;
        if (out_idx == 16) begin
          chk(done == 1'b1, "R8", "done after last byte", done, 1);
          chk(din_ready == 1'b0, "R6", "ready after job", din_ready, 0);
        end
      end
      if (out_idx < 16) begin
        start = 1'b0;
        // R3: a start in the middle of a job must be ignored
        if (busy_start && in_idx == 5 && !injected) begin
          injected = 1;
          key_in   = ~key_in;
          key_len  = 6'd7;
          start    = 1'b1;
        end
        din_valid  = (in_idx < 16) && (mode == 0 || (cyc % 3) != 0);
        din_data   = (in_idx < 16) ? cur_dat[in_idx] : 8'h00;
        dout_ready = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 4) != 1) : ((cyc % 5) < 2);
        #1;
        if (prev_hold)
          chk(dout_valid && dout_data == prev_data, "R7", "held output", dout_data, prev_data);
        if (!seen) begin
          if (din_ready) begin
            seen = 1;
            chk(lat == 257, "R4", "cycles before ready", lat, 257);
          end else begin
            lat++;
          end
        end
        pend_in   = din_valid && din_ready;
        pend_out  = dout_valid && dout_ready;
        pend_data = dout_data;
        prev_hold = dout_valid && !dout_ready;
        prev_data = dout_data;
        cyc++;
        @(negedge clk);
      end
    end
    chk(out_idx == 16, "R6", "bytes delivered", out_idx, 16);
    // R6 no further intake; R8 done stays high
    din_valid  = 1'b1;
    dout_ready = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(din_ready == 1'b0 && dout_valid == 1'b0, "R6", "extra intake", din_ready, 0);
    end
    chk(done == 1'b1, "R8", "done held", done, 1);
    din_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string pt;
    logic [71:0] vec;
    rst_n = 1'b0; start = 1'b0; key_in = '0; key_len = '0;
    din_valid = 1'b0; din_data = '0; dout_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(din_ready == 0, "R1", "din_ready in reset", din_ready, 0);
    chk(dout_valid == 0, "R1", "dout_valid in reset", dout_valid, 0);
    chk(done == 0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(din_ready == 0 && dout_valid == 0 && done == 0, "R1", "after release", done, 0);

    // Published vector, three-byte key (R2, R4, R5)
    for (int n = 0; n < 32; n++) cur_key[n] = 8'h00;
    cur_key[0] = 8'h4B; cur_key[1] = 8'h65; cur_key[2] = 8'h79;
    pt = "Plaintext";
    for (int n = 0; n < 16; n++) cur_dat[n] = (n < 9) ? pt[n] : 8'(n * 13);
    run_job(3, 0, 0);
    vec = 72'hBBF316E8D940AF0AD3;
    for (int n = 0; n < 9; n++)
      chk(got_out[n] == vec[71-8*n -: 8], "R5", "published vector", got_out[n], vec[71-8*n -: 8]);

    // R9 decrypt with the same key
    for (int n = 0; n < 16; n++) begin orig[n] = cur_dat[n]; cur_dat[n] = got_out[n]; end
    run_job(3, 1, 0);
    for (int n = 0; n < 16; n++)
      chk(got_out[n] == orig[n], "R9", "round trip", got_out[n], orig[n]);

    // 16-byte key, stalls, start injected mid-job (R3, R7)
    for (int n = 0; n < 32; n++) cur_key[n] = 8'(n * 17 + 3);
    for (int n = 0; n < 16; n++) cur_dat[n] = 8'(8'hA5 ^ (n * 29));
    run_job(16, 1, 1);

    // 32-byte key with heavy back-pressure (R2, R7)
    for (int n = 0; n < 32; n++) cur_key[n] = 8'(255 - n * 7);
    run_job(32, 2, 0);
    // R2 length above the maximum clamps to 32
    run_job(40, 0, 0);
    // R2 five-byte key
    run_job(5, 2, 0);
    // R2 zero length behaves as one byte
    run_job(0, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule